// File: doc/BRIEF.md
# Single-pass 2D integer 5/3 lifting wavelet analyser

The block takes a grayscale frame in raster order, one unsigned sample per accepted beat, and produces a one-level two-dimensional reversible 5/3 lifting decomposition of it in a single pass. Each row first goes through a streaming horizontal lifting stage. That stage pairs even-indexed and odd-indexed samples and yields one low-pass and one high-pass value for every column pair. A vertical lifting stage then runs in two lanes: one lane works on the low-pass columns and the other on the high-pass columns. It keeps three short row memories of W/2 pairs each: the pending even row, the pending odd row, and the previous vertical high-pass row. Every value is widened by three bits before any arithmetic, so the transform is exactly invertible.

Predict is `d[n] = odd[n] - floor((even[n] + even[n+1]) / 2)` and update is `s[n] = even[n] + floor((d[n-1] + d[n] + 2) / 4)`. Both divisions are arithmetic right shifts. The edges use symmetric extension. Past the right or bottom edge, the even sample at index W (or H) is replaced by the one at W-2 (or H-2). Before the left or top edge, `d[-1]` is taken equal to `d[0]`, which is the same as mirroring two samples. Once the last row of a frame has arrived, the block runs an internal bottom-edge pass over the stored rows and emits the last band row.

Both stream edges use valid/ready. A beat moves only in a cycle where valid and ready are both high. Once `out_valid` is high, it stays high and the output fields stay constant until the beat is taken. `in_ready` depends only on internal state, never on `in_valid` or `out_ready` in the same cycle. It is high when the output queue has at least four free slots and no bottom-edge pass is under way. Frame size is fixed by parameters, and W and H must both be even.

Top module: `wl53_fwd`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: Every output coefficient equals the integer 5/3 lifting result of the frame. The row transform is applied first and the column transform second, using the predict and update formulas above with floor division.
- R3: At the right and bottom edges, the missing even sample at index W (H) takes the value of the sample at index W-2 (H-2).
- R4: At the left and top edges, the first update step uses `d[0]` in place of the missing `d[-1]`.
- R5: For each band row and each column pair, four beats follow one another. Their `out_band` codes, in order, are 0 = LL, 1 = HL, 2 = LH, 3 = HH. Band rows come out top to bottom and column pairs left to right.
- R6: `out_sof` is high only on the LL beat of the first column pair of the first band row of a frame.
- R7: `out_eol` is high only on the HH beat of the last column pair of each band row.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_coef`, `out_band`, `out_sof` and `out_eol` hold their values. No coefficient is lost or duplicated under any pattern of back-pressure.
- R9: Each frame of W×H input samples yields exactly W×H output beats. In the cycle after the last sample of a frame is accepted, `in_ready` is low.
- R10: A constant frame of value v yields LL = v, and HL, LH and HH are all zero.
- R11: Full-scale inputs, including a 0 / maximum checkerboard, produce results that match R2 exactly in the (DW+3)-bit signed output, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_data | input | DW | Unsigned pixel sample, raster order |
| out_valid | output | 1 | Output coefficient offered |
| out_ready | input | 1 | Consumer takes the coefficient |
| out_coef | output | DW+3 | Signed two's-complement coefficient |
| out_band | output | 2 | Sub-band code: 0 LL, 1 HL, 2 LH, 3 HH |
| out_sof | output | 1 | First coefficient of a frame |
| out_eol | output | 1 | Last coefficient of a band row |

## Verification
The bench builds the block with DW=16, W=8, H=6 and an eight-slot output queue. With four column pairs and three band rows, every frame covers the left-edge, interior and right-edge pairs. It also covers all three kinds of band row: the top row, which has no previous vertical high-pass row; an interior row; and the bottom row, which comes from the internal flush pass. With a queue that small, a short output stall reaches `in_ready` within a few samples. Random ready patterns and one long stall therefore exercise back-pressure through every phase of a frame, including the flush.

// File: rtl/wl_pkg.sv
package wl_pkg;
  localparam logic [1:0] BAND_LL = 2'd0;
  localparam logic [1:0] BAND_HL = 2'd1;
  localparam logic [1:0] BAND_LH = 2'd2;
  localparam logic [1:0] BAND_HH = 2'd3;
endpackage

// File: rtl/wl_lift.sv
// One 5/3 lifting pair: predict then update, both floor via arithmetic shift.
module wl_lift #(
  parameter int IW = 19
) (
  input  logic signed [IW-1:0] ev,
  input  logic signed [IW-1:0] od,
  input  logic signed [IW-1:0] ev_nx,
  input  logic signed [IW-1:0] d_left,
  input  logic                 use_self,
  output logic signed [IW-1:0] hi,
  output logic signed [IW-1:0] lo
);
  logic signed [IW:0]   esum;
  logic signed [IW:0]   dsum;
  logic signed [IW-1:0] dl;

  always_comb begin
    esum = {ev[IW-1], ev} + {ev_nx[IW-1], ev_nx};
    hi   = od - $signed(esum[IW:1]);
    dl   = use_self ? hi : d_left;
    dsum = {dl[IW-1], dl} + {hi[IW-1], hi} + (IW+1)'(2);
    lo   = ev + $signed({dsum[IW], dsum[IW:2]});
  end
endmodule

// File: rtl/wl_qfifo.sv
// Output queue: writes four entries at once, reads one per cycle.
module wl_qfifo #(
  parameter int EW    = 23,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [4*EW-1:0] push_data,
  output logic            space,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [EW-1:0]   out_data
);
  localparam int AW = $clog2(DEPTH);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          pop;

  assign out_valid = cnt != '0;
  assign out_data  = mem[rp];
  assign pop       = out_valid && out_ready;
  assign space     = cnt <= (AW+1)'(DEPTH-4);

  always_ff @(posedge clk) begin
    if (push) begin
      for (int i = 0; i < 4; i++) mem[wp + AW'(i)] <= push_data[EW*i +: EW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + AW'(4);
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + (push ? (AW+1)'(4) : '0) - (pop ? (AW+1)'(1) : '0);
    end
  end

  // R8: an offered entry is held until taken
  p_out_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R8: a four-entry push never lands on a queue without room
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt <= (AW+1)'(DEPTH-4)));
endmodule

// File: rtl/wl53_fwd.sv
module wl53_fwd
  import wl_pkg::*;
#(
  parameter int DW = 16,
  parameter int W  = 640,
  parameter int H  = 480,
  parameter int FD = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW+2:0] out_coef,
  output logic [1:0]    out_band,
  output logic          out_sof,
  output logic          out_eol
);
  localparam int IW = DW + 3;
  localparam int NP = W / 2;
  localparam int CB = $clog2(W);
  localparam int PW = CB - 1;
  localparam int RB = $clog2(H + 1);
  localparam int EW = IW + 4;

  logic [CB-1:0]        col;
  logic [RB-1:0]        row;
  logic                 flushing;
  logic [PW-1:0]        fidx;
  logic signed [IW-1:0] e_cur, o_cur, hd_prev;

  logic                 acc, col_even, last_col, h_done, q_space, v_go, v_first;
  logic [PW-1:0]        hn, vn;
  logic signed [IW-1:0] xs, h_od, h_nx, h_hi, h_lo;
  logic [1:0][IW-1:0]   lane_s, lane_d;
  logic                 sof_b, eol_b;
  logic [4*EW-1:0]      q_in;
  logic [EW-1:0]        q_out;

  assign in_ready = !flushing && q_space;
  assign acc      = in_valid && in_ready;
  assign xs       = $signed({3'b000, in_data});
  assign col_even = !col[0];
  assign last_col = col == CB'(W-1);
  assign h_done   = acc && ((col_even && col != '0) || last_col);
  assign hn       = last_col ? PW'(NP-1) : PW'(col[CB-1:1] - 1'b1);
  assign h_od     = last_col ? xs : o_cur;
  assign h_nx     = last_col ? e_cur : xs;

  // horizontal lifting on the live stream
  wl_lift #(.IW(IW)) u_hlift (
    .ev(e_cur), .od(h_od), .ev_nx(h_nx), .d_left(hd_prev),
    .use_self(hn == '0), .hi(h_hi), .lo(h_lo)
  );

  assign v_go    = (h_done && row != '0 && !row[0]) || (flushing && q_space);
  assign v_first = flushing ? (H == 2) : (row == RB'(2));
  assign vn      = flushing ? fidx : hn;

  // vertical lifting: lane 0 low-pass columns, lane 1 high-pass columns
  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic signed [IW-1:0] eb [NP];
    logic signed [IW-1:0] ob [NP];
    logic signed [IW-1:0] db [NP];
    logic signed [IW-1:0] xin, vd, vs;

    assign xin = flushing ? eb[vn] : ((k == 0) ? h_lo : h_hi);

    wl_lift #(.IW(IW)) u_vlift (
      .ev(eb[vn]), .od(ob[vn]), .ev_nx(xin), .d_left(db[vn]),
      .use_self(v_first), .hi(vd), .lo(vs)
    );

    always_ff @(posedge clk) begin
      if (h_done && row == '0) begin
        eb[hn] <= xin;
      end else if (h_done && row[0]) begin
        ob[hn] <= xin;
      end else if (v_go && !flushing) begin
        eb[hn] <= xin;
        db[hn] <= vd;
      end
    end

    assign lane_s[k] = vs;
    assign lane_d[k] = vd;
  end

  assign sof_b = v_first && vn == '0;
  assign eol_b = vn == PW'(NP-1);
  assign q_in  = {lane_d[1], BAND_HH, 1'b0, eol_b,
                  lane_d[0], BAND_LH, 2'b00,
                  lane_s[1], BAND_HL, 2'b00,
                  lane_s[0], BAND_LL, sof_b, 1'b0};

  wl_qfifo #(.EW(EW), .DEPTH(FD)) u_q (
    .clk(clk), .rst_n(rst_n), .push(v_go), .push_data(q_in), .space(q_space),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(q_out)
  );

  assign out_coef = q_out[EW-1:4];
  assign out_band = q_out[3:2];
  assign out_sof  = q_out[1];
  assign out_eol  = q_out[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col      <= '0;
      row      <= '0;
      flushing <= 1'b0;
      fidx     <= '0;
      e_cur    <= '0;
      o_cur    <= '0;
      hd_prev  <= '0;
    end else begin
      if (acc) begin
        if (col_even) e_cur <= xs;
        else          o_cur <= xs;
        if (h_done) hd_prev <= h_hi;
        if (last_col) begin
          col <= '0;
          if (row == RB'(H-1)) begin
            row      <= '0;
            flushing <= 1'b1;
            fidx     <= '0;
          end else begin
            row <= row + 1'b1;
          end
        end else begin
          col <= col + 1'b1;
        end
      end
      if (flushing && q_space) begin
        if (fidx == PW'(NP-1)) flushing <= 1'b0;
        fidx <= fidx + 1'b1;
      end
    end
  end

  // R6: frame start marker only on an LL beat
  p_sof_ll_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> (out_band == BAND_LL));
  // R7: row end marker only on an HH beat
  p_eol_hh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eol) |-> (out_band == BAND_HH));
  // R9: last sample of a frame closes the input for the edge pass
  p_close_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && last_col && row == RB'(H-1)) |=> !in_ready);
endmodule

// File: tb/wl53_fwd_tb.sv
`timescale 1ns/1ps
module wl53_fwd_tb;
  localparam int DW = 16;
  localparam int W  = 8;
  localparam int H  = 6;
  localparam int MAXV = (1 << DW) - 1;

  typedef int vec_t [16];
  typedef int half_t [8];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [DW+2:0] out_coef;
  logic [1:0] out_band;
  logic out_sof, out_eol;

  always #2.5 clk = ~clk;

  wl53_fwd #(.DW(DW), .W(W), .H(H), .FD(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_coef(out_coef), .out_band(out_band), .out_sof(out_sof), .out_eol(out_eol)
  );

  int n_chk = 0, n_fail = 0;
  int pix [H][W];
  int e_coef [2048];
  int e_band [2048];
  int e_sof [2048];
  int e_eol [2048];
  int n_exp = 0, n_got = 0;
  int rdy_pct = 100;
  string cur_req = "R2";
  bit mon_on = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic lift(input vec_t x, input int n, output half_t lo, output half_t hi);
    int m = n / 2;
    for (int i = 0; i < m; i++) begin
      int r = (2*i + 2 < n) ? x[2*i + 2] : x[n - 2];
      hi[i] = x[2*i + 1] - ((x[2*i] + r) >>> 1);
    end
    for (int i = 0; i < m; i++) begin
      int l = (i == 0) ? hi[0] : hi[i - 1];
      lo[i] = x[2*i] + ((l + hi[i] + 2) >>> 2);
    end
  endtask

  // behavioural model: rows first, then columns; append expected beats
  task automatic model_frame();
    int hl [H][8];
    int hh [H][8];
    int ll_o [8][8];
    int lh_o [8][8];
    int hl_o [8][8];
    int hh_o [8][8];
    vec_t x;
    half_t lo, hi;
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) x[c] = pix[r][c];
      lift(x, W, lo, hi);
      for (int n = 0; n < W/2; n++) begin hl[r][n] = lo[n]; hh[r][n] = hi[n]; end
    end
    for (int n = 0; n < W/2; n++) begin
      for (int r = 0; r < H; r++) x[r] = hl[r][n];
      lift(x, H, lo, hi);
      for (int v = 0; v < H/2; v++) begin ll_o[v][n] = lo[v]; lh_o[v][n] = hi[v]; end
      for (int r = 0; r < H; r++) x[r] = hh[r][n];
      lift(x, H, lo, hi);
      for (int v = 0; v < H/2; v++) begin hl_o[v][n] = lo[v]; hh_o[v][n] = hi[v]; end
    end
    for (int v = 0; v < H/2; v++)
      for (int n = 0; n < W/2; n++) begin
        e_coef[n_exp] = ll_o[v][n]; e_band[n_exp] = 0;
        e_sof[n_exp] = (v == 0 && n == 0); e_eol[n_exp] = 0; n_exp++;
        e_coef[n_exp] = hl_o[v][n]; e_band[n_exp] = 1;
        e_sof[n_exp] = 0; e_eol[n_exp] = 0; n_exp++;
        e_coef[n_exp] = lh_o[v][n]; e_band[n_exp] = 2;
        e_sof[n_exp] = 0; e_eol[n_exp] = 0; n_exp++;
        e_coef[n_exp] = hh_o[v][n]; e_band[n_exp] = 3;
        e_sof[n_exp] = 0; e_eol[n_exp] = (n == W/2 - 1); n_exp++;
      end
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic put(int v, int gap);
    repeat (gap) @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(v);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_frame(int kind, int max_gap);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        case (kind)
          0: pix[r][c] = 1234;
          1: pix[r][c] = MAXV;
          2: pix[r][c] = ((r + c) % 2 == 0) ? 0 : MAXV;
          3: pix[r][c] = 1000 * c + 37 * r;
          default: pix[r][c] = int'($urandom_range(MAXV, 0));
        endcase
    model_frame();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        put(pix[r][c], (max_gap == 0) ? 0 : int'($urandom_range(max_gap, 0)));
    check(in_ready == 1'b0, "R9", "in_ready after last sample", int'(in_ready), 0);
  endtask

  // output monitor: decide ready at the falling edge, compare taken beats
  bit pend = 1'b0;
  logic [DW+2:0] held_coef;
  logic [1:0] held_band;
  always @(negedge clk) begin
    if (mon_on) begin
      if (pend) begin
        check(out_valid == 1'b1, "R8", "valid held during stall", int'(out_valid), 1);
        check(out_coef == held_coef && out_band == held_band, "R8", "data held during stall",
              int'($signed(out_coef)), int'($signed(held_coef)));
      end
      out_ready = (int'($urandom_range(99, 0)) < rdy_pct);
      if (out_valid && out_ready) begin
        if (n_got >= n_exp) begin
          check(1'b0, "R9", "extra output beat", n_got, n_exp);
        end else begin
          check(int'($signed(out_coef)) == e_coef[n_got], cur_req,
                "R2 R3 R4 coefficient", int'($signed(out_coef)), e_coef[n_got]);
          check(int'(out_band) == e_band[n_got], "R5", "band code", int'(out_band), e_band[n_got]);
          check(int'(out_sof) == e_sof[n_got], "R6", "sof flag", int'(out_sof), e_sof[n_got]);
          check(int'(out_eol) == e_eol[n_got], "R7", "eol flag", int'(out_eol), e_eol[n_got]);
        end
        n_got++;
      end
      pend = out_valid && !out_ready;
      held_coef = out_coef;
      held_band = out_band;
    end
  end

  task automatic drain();
    while (n_got < n_exp) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog expired: beats %0d expected %0d", n_got, n_exp);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    mon_on = 1'b1;

    cur_req = "R10"; rdy_pct = 100; send_frame(0, 0); drain();
    cur_req = "R11"; send_frame(1, 0); drain();
    cur_req = "R11"; rdy_pct = 70; send_frame(2, 1); drain();
    cur_req = "R3";  rdy_pct = 100; send_frame(3, 0); drain();
    cur_req = "R4";  rdy_pct = 50; send_frame(3, 2); drain();
    cur_req = "R2";
    for (int f = 0; f < 5; f++) begin
      rdy_pct = 30 + 15 * f;
      send_frame(4, f % 3);
    end
    drain();

    // long output stall while a frame is being fed (R8)
    cur_req = "R8";
    rdy_pct = 0;
    fork
      send_frame(4, 0);
      begin repeat (60) @(negedge clk); rdy_pct = 100; end
    join
    drain();

    repeat (20) @(negedge clk);
    check(n_got == n_exp, "R9", "total beat count", n_got, n_exp);
    check(out_valid == 1'b0, "R9", "no beat after frames", int'(out_valid), 0);
    finish_run();
  end
endmodule